// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This block sits between the register read stage and the data memory port of a load/store pipeline. From a base register value and an offset it forms the byte address used for the memory access, and it forms the updated base value that the register file may take back. The offset is either a 12-bit unsigned constant or a register value passed through a barrel shifter, and it is added to or subtracted from the base. Three addressing modes are supported. Plain offset mode never touches the base. Pre-indexed mode uses the computed address and writes it back only on request. Post-indexed mode accesses memory at the untouched base and always writes back the computed value.

When the base is the program counter, the unit uses the instruction address plus a fixed look-ahead of 8. Writeback to the program counter is illegal. The unit raises a flag for it and suppresses the write enable. On the data side, the unit produces little-endian byte enables. It replicates the low byte of store data across all lanes for byte stores, and it zero-extends the addressed byte of the returned load data for byte loads. Address, enables and data paths are combinational. The writeback value, its enable and the illegal-writeback flag are registered and appear one cycle after the request under a valid strobe.

Top module: `lsu_addr_unit`

## Requirements
- R1: With mode code 2 (post-index), mem_addr equals the base value, and wb_value one cycle later equals base plus or minus the offset, with wb_en high.
- R2: With mode code 1 (pre-index), mem_addr equals base plus or minus the offset. wb_en one cycle later is high only when wb_req was high, and wb_value then equals mem_addr.
- R3: With mode code 0 (offset), and with the reserved mode code 3, mem_addr equals base plus or minus the offset, and wb_en stays low.
- R4: When off_sub is high the offset is subtracted, and otherwise it is added. With use_reg_off low the offset is imm_off zero-extended, and arithmetic wraps modulo 2^32.
- R5: With use_reg_off high the offset is reg_off shifted by sh_amt (0 to 31). sh_kind 0 is a logical left shift, 1 a logical right shift, 2 an arithmetic right shift, and 3 a rotate right. For kinds 1 and 2 an amount of 0 means a shift by 32, giving 0 or all sign bits. For kinds 0 and 3 an amount of 0 leaves the value unchanged.
- R6: When base_is_pc is high, the base value used is pc_val + 8 and base_val is ignored.
- R7: When base_is_pc is high and a writeback would occur (mode 2, or mode 1 with wb_req), pc_wb_err is high one cycle later and wb_en is low. In all other cases pc_wb_err is low.
- R8: For a word access all four bits of byte_en are high. For a byte access byte_en is one-hot with bit mem_addr[1:0] set. With req_valid low, byte_en is 0.
- R9: wr_data equals st_data for a word access. For a byte access it is st_data[7:0] copied into all four byte lanes.
- R10: ld_result equals ld_data for a word access. For a byte access it is byte lane mem_addr[1:0] of ld_data (lane 0 = bits 7:0) zero-extended to 32 bits.
- R11: wb_valid is high exactly in the cycle after a cycle with req_valid high. When wb_valid is low, wb_en and pc_wb_err are low. All three registers and wb_value reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| base_val | input | 32 | Base register value |
| base_is_pc | input | 1 | Base register is the program counter |
| pc_val | input | 32 | Address of the current instruction |
| use_reg_off | input | 1 | 1: shifted register offset, 0: immediate |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register offset before shifting |
| sh_kind | input | 2 | Shift type: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| sh_amt | input | 5 | Shift amount |
| off_sub | input | 1 | 1: subtract offset, 0: add |
| mode | input | 2 | 0 offset, 1 pre-index, 2 post-index, 3 reserved (as offset) |
| wb_req | input | 1 | Writeback requested (pre-index) |
| is_byte | input | 1 | 1: byte access, 0: word access |
| st_data | input | 32 | Store data from the register file |
| ld_data | input | 32 | Word returned by memory |
| mem_addr | output | 32 | Effective memory address |
| byte_en | output | 4 | Byte lane enables |
| wr_data | output | 32 | Store data placed on the lanes |
| ld_result | output | 32 | Load value, zero-extended for bytes |
| wb_valid | output | 1 | Registered result of a request present |
| wb_en | output | 1 | Base register writeback enable |
| wb_value | output | 32 | New base register value |
| pc_wb_err | output | 1 | Illegal writeback to the program counter flagged |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath, a 12-bit immediate and a program counter look-ahead of 8. With these defaults every shift amount from 0 to 31 can be reached, including the zero amount that turns into a shift by 32. The largest immediate of 4095 and subtraction below zero exercise the wrap-around. The two low address bits reach all four byte lanes, so each lane's enable, replication and extraction is checked against the behavioural model through both directed and random vectors.

// File: rtl/lsu_addr_pkg.sv
package lsu_addr_pkg;

    typedef enum logic [1:0] {
        MD_OFFSET = 2'd0,
        MD_PRE    = 2'd1,
        MD_POST   = 2'd2,
        MD_RSVD   = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

endpackage

// File: rtl/lsu_offset_shifter.sv
module lsu_offset_shifter
    import lsu_addr_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] value,
    input  logic [1:0]        kind,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] result
);

    shift_kind_e kind_e;
    logic [SH_W-1:0] back_amt;

    assign kind_e   = shift_kind_e'(kind);
    // complement amount for the rotate's left part; wraps to DATA_W - amt
    assign back_amt = SH_W'(0) - amt;

    always_comb begin
        result = value;
        unique case (kind_e)
            SH_LSL: result = value << amt;
            SH_LSR: result = (amt == '0) ? '0 : (value >> amt);
            SH_ASR: result = (amt == '0) ? {DATA_W{value[DATA_W-1]}}
                                         : DATA_W'($signed(value) >>> amt);
            SH_ROR: result = (amt == '0) ? value
                                         : ((value >> amt) | (value << back_amt));
            default: result = value;
        endcase
    end

endmodule

// File: rtl/lsu_ea_calc.sv
module lsu_ea_calc
    import lsu_addr_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 12,
    parameter int PC_AHEAD = 8
) (
    input  logic [DATA_W-1:0] base_val,
    input  logic              base_is_pc,
    input  logic [DATA_W-1:0] pc_val,
    input  logic              use_reg_off,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [DATA_W-1:0] shifted_off,
    input  logic              off_sub,
    input  logic [1:0]        mode,
    input  logic              wb_req,
    output logic [DATA_W-1:0] ea,
    output logic [DATA_W-1:0] next_base,
    output logic              wb_ok,
    output logic              pc_wb_bad
);

    addr_mode_e        mode_e;
    logic [DATA_W-1:0] base_eff;
    logic [DATA_W-1:0] offset;
    logic [DATA_W-1:0] moved;
    logic              wants_wb;

    assign mode_e   = addr_mode_e'(mode);
    assign base_eff = base_is_pc ? (pc_val + DATA_W'(PC_AHEAD)) : base_val;
    assign offset   = use_reg_off ? shifted_off : DATA_W'(imm_off);
    assign moved    = off_sub ? (base_eff - offset) : (base_eff + offset);

    always_comb begin
        ea       = moved;
        wants_wb = 1'b0;
        unique case (mode_e)
            MD_PRE:  wants_wb = wb_req;
            MD_POST: begin
                ea       = base_eff;
                wants_wb = 1'b1;
            end
            default: wants_wb = 1'b0;
        endcase
    end

    assign next_base = moved;
    assign wb_ok     = wants_wb & ~base_is_pc;
    assign pc_wb_bad = wants_wb &  base_is_pc;

endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane #(
    parameter int DATA_W  = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic              active,
    input  logic              is_byte,
    input  logic [LANE_W-1:0] lane_sel,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] ld_data,
    output logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ld_result
);

    logic [7:0] ld_lanes [LANES];
    logic [7:0] picked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_en[g]        = active & (~is_byte | (lane_sel == LANE_W'(g)));
        assign wr_data[8*g +: 8] = is_byte ? st_data[7:0] : st_data[8*g +: 8];
        assign ld_lanes[g]       = ld_data[8*g +: 8];
    end

    assign picked    = ld_lanes[lane_sel];
    assign ld_result = is_byte ? DATA_W'(picked) : ld_data;

endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit #(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 12,
    parameter int PC_AHEAD = 8,
    localparam int SH_W    = $clog2(DATA_W),
    localparam int LANES   = DATA_W / 8,
    localparam int LANE_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] base_val,
    input  logic              base_is_pc,
    input  logic [DATA_W-1:0] pc_val,
    input  logic              use_reg_off,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [DATA_W-1:0] reg_off,
    input  logic [1:0]        sh_kind,
    input  logic [SH_W-1:0]   sh_amt,
    input  logic              off_sub,
    input  logic [1:0]        mode,
    input  logic              wb_req,
    input  logic              is_byte,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] ld_data,
    output logic [DATA_W-1:0] mem_addr,
    output logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ld_result,
    output logic              wb_valid,
    output logic              wb_en,
    output logic [DATA_W-1:0] wb_value,
    output logic              pc_wb_err
);

    typedef struct packed {
        logic              valid;
        logic              en;
        logic              err;
        logic [DATA_W-1:0] value;
    } wb_state_t;

    logic [DATA_W-1:0] shifted_off;
    logic [DATA_W-1:0] next_base;
    logic              wb_ok;
    logic              pc_wb_bad;
    wb_state_t         wb_d, wb_q;

    lsu_offset_shifter #(.DATA_W(DATA_W)) u_shift (
        .value  (reg_off),
        .kind   (sh_kind),
        .amt    (sh_amt),
        .result (shifted_off)
    );

    lsu_ea_calc #(
        .DATA_W   (DATA_W),
        .IMM_W    (IMM_W),
        .PC_AHEAD (PC_AHEAD)
    ) u_ea (
        .base_val    (base_val),
        .base_is_pc  (base_is_pc),
        .pc_val      (pc_val),
        .use_reg_off (use_reg_off),
        .imm_off     (imm_off),
        .shifted_off (shifted_off),
        .off_sub     (off_sub),
        .mode        (mode),
        .wb_req      (wb_req),
        .ea          (mem_addr),
        .next_base   (next_base),
        .wb_ok       (wb_ok),
        .pc_wb_bad   (pc_wb_bad)
    );

    lsu_byte_lane #(.DATA_W(DATA_W)) u_lane (
        .active    (req_valid),
        .is_byte   (is_byte),
        .lane_sel  (mem_addr[LANE_W-1:0]),
        .st_data   (st_data),
        .ld_data   (ld_data),
        .byte_en   (byte_en),
        .wr_data   (wr_data),
        .ld_result (ld_result)
    );

    always_comb begin
        wb_d       = wb_q;
        wb_d.valid = req_valid;
        wb_d.en    = req_valid & wb_ok;
        wb_d.err   = req_valid & pc_wb_bad;
        if (req_valid) begin
            wb_d.value = next_base;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wb_q <= '0;
        end else begin
            wb_q <= wb_d;
        end
    end

    assign wb_valid  = wb_q.valid;
    assign wb_en     = wb_q.en;
    assign wb_value  = wb_q.value;
    assign pc_wb_err = wb_q.err;

endmodule

// File: rtl/lsu_addr_unit_chk.sv
module lsu_addr_unit_chk #(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 12,
    parameter int PC_AHEAD = 8,
    localparam int SH_W    = $clog2(DATA_W),
    localparam int LANES   = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [DATA_W-1:0] base_val,
    input logic              base_is_pc,
    input logic [DATA_W-1:0] pc_val,
    input logic              use_reg_off,
    input logic [IMM_W-1:0]  imm_off,
    input logic [DATA_W-1:0] reg_off,
    input logic [1:0]        sh_kind,
    input logic [SH_W-1:0]   sh_amt,
    input logic              off_sub,
    input logic [1:0]        mode,
    input logic              wb_req,
    input logic              is_byte,
    input logic [DATA_W-1:0] st_data,
    input logic [DATA_W-1:0] ld_data,
    input logic [DATA_W-1:0] mem_addr,
    input logic [LANES-1:0]  byte_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] ld_result,
    input logic              wb_valid,
    input logic              wb_en,
    input logic [DATA_W-1:0] wb_value,
    input logic              pc_wb_err
);

    a_r1_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'd2 && !base_is_pc) |-> (mem_addr == base_val));

    a_r1_post_writes_back: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'd2 && !base_is_pc) |=> wb_en);

    a_r2_pre_wb_is_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == 2'd1 && wb_req && !base_is_pc) |=> (wb_en && wb_value == $past(mem_addr)));

    a_r3_offset_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (mode == 2'd0 || mode == 2'd3)) |=> !wb_en);

    a_r6_pc_look_ahead: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_is_pc && mode == 2'd2) |-> (mem_addr == pc_val + DATA_W'(PC_AHEAD)));

    a_r7_pc_never_written: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && base_is_pc) |=> !wb_en);

    a_r7_err_excludes_wb: assert property (@(posedge clk) disable iff (!rst_n)
        !(wb_en && pc_wb_err));

    a_r8_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_byte) |-> ($countones(byte_en) == 1));

    a_r8_word_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_byte) |-> (byte_en == '1));

    a_r8_idle_no_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (byte_en == '0));

    a_r9_byte_replicated: assert property (@(posedge clk) disable iff (!rst_n)
        is_byte |-> (wr_data[15:8] == st_data[7:0] && wr_data[DATA_W-1 -: 8] == st_data[7:0]));

    a_r10_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        is_byte |-> (ld_result[DATA_W-1:8] == '0));

    a_r11_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> wb_valid);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wb_valid |-> (!wb_en && !pc_wb_err));

endmodule

bind lsu_addr_unit lsu_addr_unit_chk #(
    .DATA_W   (DATA_W),
    .IMM_W    (IMM_W),
    .PC_AHEAD (PC_AHEAD)
) u_chk (.*);

// File: tb/lsu_addr_unit_tb.sv
module lsu_addr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic        base_is_pc = 1'b0;
    logic [31:0] pc_val = '0;
    logic        use_reg_off = 1'b0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic [1:0]  sh_kind = '0;
    logic [4:0]  sh_amt = '0;
    logic        off_sub = 1'b0;
    logic [1:0]  mode = '0;
    logic        wb_req = 1'b0;
    logic        is_byte = 1'b0;
    logic [31:0] st_data = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] mem_addr, wr_data, ld_result, wb_value;
    logic [3:0]  byte_en;
    logic        wb_valid, wb_en, pc_wb_err;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    lsu_addr_unit u_dut (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic longint shifted_ref(longint v, int kind, int amt);
        longint s;
        case (kind)
            0: return (v << amt) & 64'hFFFF_FFFF;
            1: return (amt == 0) ? 0 : (v >> amt);
            2: begin
                s = (v >= 64'h8000_0000) ? (v - 64'h1_0000_0000) : v;
                return (s >>> ((amt == 0) ? 32 : amt)) & 64'hFFFF_FFFF;
            end
            default: return ((v | (v << 32)) >> amt) & 64'hFFFF_FFFF;
        endcase
    endfunction

    // apply current inputs as a request, check combinational then registered outputs
    task automatic apply();
        longint base, off, sum, addr, lane, exp_be, exp_wd, exp_ld;
        bit want;
        string tag;
        @(negedge clk);
        req_valid = 1'b1;
        base = base_is_pc ? ((longint'(pc_val) + 8) & 64'hFFFF_FFFF) : longint'(base_val);
        off  = use_reg_off ? shifted_ref(longint'(reg_off), int'(sh_kind), int'(sh_amt)) : longint'(imm_off);
        sum  = (off_sub ? (base - off) : (base + off)) & 64'hFFFF_FFFF;
        addr = (mode == 2'd2) ? base : sum;
        want = (mode == 2'd2) || (mode == 2'd1 && wb_req);
        tag  = (mode == 2'd2) ? "R1" : (mode == 2'd1) ? "R2" : "R3";
        if (use_reg_off) tag = {tag, "/R5"};
        if (base_is_pc) tag = {tag, "/R6"};
        lane   = addr % 4;
        exp_be = is_byte ? (1 << lane) : 15;
        exp_wd = is_byte ? (longint'(st_data[7:0]) * 64'h0101_0101) : longint'(st_data);
        exp_ld = is_byte ? ((longint'(ld_data) >> (8 * lane)) & 255) : longint'(ld_data);
        #1;
        chk({tag, "/R4 mem_addr"}, longint'(mem_addr), addr);
        chk("R8 byte_en", longint'(byte_en), exp_be);
        chk("R9 wr_data", longint'(wr_data), exp_wd);
        chk("R10 ld_result", longint'(ld_result), exp_ld);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        chk("R11 wb_valid", longint'(wb_valid), 1);
        chk({tag, "/R7 wb_en"}, longint'(wb_en), longint'(want && !base_is_pc));
        chk("R7 pc_wb_err", longint'(pc_wb_err), longint'(want && base_is_pc));
        if (want && !base_is_pc) chk({tag, " wb_value"}, longint'(wb_value), sum);
    endtask

    task automatic set_req(input logic [31:0] b, input logic [1:0] md, input logic wr,
                           input logic sub, input logic [11:0] imm);
        base_val = b; mode = md; wb_req = wr; off_sub = sub; imm_off = imm;
        use_reg_off = 1'b0; base_is_pc = 1'b0; is_byte = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset wb_valid", longint'(wb_valid), 0);
        chk("R11 reset wb_en", longint'(wb_en), 0);
        chk("R11 reset wb_value", longint'(wb_value), 0);
        chk("R11 reset pc_wb_err", longint'(pc_wb_err), 0);
        rst_n = 1'b1;
        st_data = 32'hA1B2_C3D4;
        ld_data = 32'h8899_AABB;

        // R1 post-index, R2 pre with/without writeback, R3 offset and reserved mode
        set_req(32'h0000_5000, 2'd2, 1'b0, 1'b0, 12'd4);    apply();
        set_req(32'h0000_0200, 2'd1, 1'b1, 1'b0, 12'd12);   apply();
        set_req(32'h0000_0200, 2'd1, 1'b0, 1'b0, 12'd12);   apply();
        set_req(32'h0000_1000, 2'd0, 1'b1, 1'b0, 12'hFFF);  apply();
        set_req(32'h0000_1000, 2'd3, 1'b1, 1'b1, 12'h010);  apply();
        // R4 subtraction wrapping below zero
        set_req(32'h0000_0003, 2'd1, 1'b1, 1'b1, 12'd8);    apply();

        // R5 each shift type with zero and non-zero amounts
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 32; a += 31) begin
                set_req(32'h0001_0000, 2'd1, 1'b1, 1'b0, 12'd0);
                use_reg_off = 1'b1; reg_off = 32'h8000_0F01;
                sh_kind = 2'(k); sh_amt = 5'(a);
                apply();
                sh_amt = 5'd5; apply();
            end
        end

        // R6/R7 program counter as base
        set_req(32'hDEAD_BEEF, 2'd2, 1'b0, 1'b0, 12'd996);
        base_is_pc = 1'b1; pc_val = 32'h0000_0100; apply();
        set_req(32'hDEAD_BEEF, 2'd0, 1'b0, 1'b0, 12'd996);
        base_is_pc = 1'b1; apply();
        set_req(32'hDEAD_BEEF, 2'd1, 1'b1, 1'b1, 12'd4);
        base_is_pc = 1'b1; apply();

        // R8/R9/R10 byte access on every lane
        for (int l = 0; l < 4; l++) begin
            set_req(32'h2000_0000 + 32'(l), 2'd0, 1'b0, 1'b0, 12'd0);
            is_byte = 1'b1; apply();
        end

        // R11 idle cycle
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R8 idle byte_en", longint'(byte_en), 0);
        @(posedge clk);
        #1;
        chk("R11 idle wb_valid", longint'(wb_valid), 0);
        chk("R11 idle wb_en", longint'(wb_en), 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            base_val = $urandom; pc_val = $urandom; reg_off = $urandom;
            imm_off = 12'($urandom); sh_kind = 2'($urandom); sh_amt = 5'($urandom);
            use_reg_off = 1'($urandom); off_sub = 1'($urandom); mode = 2'($urandom);
            wb_req = 1'($urandom); is_byte = 1'($urandom);
            base_is_pc = (($urandom % 8) == 0);
            st_data = $urandom; ld_data = $urandom;
            apply();
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule